// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Scoped Invalidation

This block is a small, fully associative cache of completed address translations for an I/O memory management unit. Each entry is keyed by a 16-bit address-space identifier and a 64-bit input address. Its payload is the translated output address, a mask giving the size of the mapped span, and the access permissions. A page table walker writes finished translations through the fill port. Translation requests query the cache through the lookup port and get hit or miss, plus the cached payload, a fixed one cycle later.

Software-driven maintenance reaches the cache through an invalidation port with three scopes:
- every entry;
- every entry of one identifier;
- the single entry matching an exact identifier-and-address pair.

An invalidation always wins over work in the same cycle. A lookup in that cycle sees the cache as if the invalidation had already happened. A fill is held off with back-pressure.

When no entry is free, a fill replaces entries in round-robin order.

Lookup and fill are valid/ready streams; a transfer happens on a clock edge where both are high. Lookups are never back-pressured: `lk_ready` is always high. `fill_ready` is low in exactly the cycles where `inv_valid` is high. A walker must then hold its fill, unchanged, until a cycle with `fill_ready` high. The response has no ready: it is a one-cycle pulse that the requester must take.

Top module: `iotlb_cache`

## Requirements
- R1: A lookup hits only when a valid entry's stored identifier and stored address both equal the request's identifier and address, bit for bit.
- R2: `lk_ready` is always 1. For each accepted lookup, `rsp_valid` is 1 on the following cycle only, together with `rsp_hit` and, on a hit, that entry's output address, mask and permissions. On a miss the three payload outputs are 0.
- R3: `fill_ready` is 0 exactly when `inv_valid` is 1. An accepted fill is visible to lookups from the next cycle on. A lookup in the same cycle as the fill does not see it.
- R4: A fill whose key equals that of a valid entry overwrites that entry and creates no second copy.
- R5: A fill with a new key goes to the lowest-numbered free entry when one exists. The round-robin pointer does not move.
- R6: With every entry valid, a fill with a new key replaces the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after the last entry, on each such replacement only.
- R7: `inv_cmd` 2'b00 clears every valid entry.
- R8: `inv_cmd` 2'b01 clears every entry whose identifier equals `inv_asid` and leaves all others intact.
- R9: `inv_cmd` 2'b10 clears only the entry whose identifier and address equal `inv_asid` and `inv_addr`.
- R10: `inv_cmd` 2'b11 changes no entry.
- R11: An invalidation applies before a lookup in the same cycle, so that lookup cannot hit an entry being cleared.
- R12: While `rst` is high at a clock edge the cache is emptied and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready, always 1 |
| lk_asid | input | 16 | Lookup identifier |
| lk_addr | input | 64 | Lookup input address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_oaddr | output | 48 | Cached output address (0 on miss) |
| rsp_mask | output | 48 | Cached span mask (0 on miss) |
| rsp_perm | output | 2 | Cached permissions (0 on miss) |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill request ready |
| fill_asid | input | 16 | Fill identifier |
| fill_addr | input | 64 | Fill input address |
| fill_oaddr | input | 48 | Fill output address |
| fill_mask | input | 48 | Fill span mask |
| fill_perm | input | 2 | Fill permissions |
| inv_valid | input | 1 | Invalidation command valid |
| inv_cmd | input | 2 | 00 all, 01 by identifier, 10 exact pair, 11 none |
| inv_asid | input | 16 | Invalidation identifier |
| inv_addr | input | 64 | Invalidation address |

## Verification
Response timing:
- A lookup's response is registered once and appears on the cycle after the edge that accepts it.
- A fill or an invalidation changes entry state at its edge and is first observable through a lookup issued on the next cycle.

The bench drives each request half a cycle before an edge. It reads the response at the falling edge after that, and `fill_ready` in the same half cycle in which it drives `inv_valid`.

Same-cycle orderings are checked by putting two requests on one edge and reading the single response:
- invalidation with lookup;
- fill with lookup.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  typedef enum logic [1:0] {
    INV_ALL   = 2'b00,
    INV_ASID  = 2'b01,
    INV_EXACT = 2'b10,
    INV_NOP   = 2'b11
  } inv_cmd_e;
endpackage

// File: rtl/iotlb_tag_match.sv
module iotlb_tag_match #(
  parameter int N      = 16,
  parameter int ASID_W = 16,
  parameter int VA_W   = 64
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][ASID_W-1:0] asid_tags,
  input  logic [N-1:0][VA_W-1:0]   addr_tags,
  input  logic [ASID_W-1:0]        q_asid,
  input  logic [VA_W-1:0]          q_addr,
  input  logic                     asid_only,
  output logic [N-1:0]             hit
);
  // One comparator pair per entry; address compare skipped for identifier-wide queries.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = valid[g] && (asid_tags[g] == q_asid) &&
                    (asid_only || (addr_tags[g] == q_addr));
  end
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     key_hit,
  input  logic             fill_fire,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx, hit_idx;
  logic             free_found, any_hit, evict;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    any_hit    = 1'b0;
    hit_idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (key_hit[i]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign victim = any_hit ? hit_idx : (free_found ? free_idx : rr_q);
  assign evict  = fill_fire && !any_hit && !free_found;

  always_ff @(posedge clk) begin
    if (rst)        rr_q <= '0;
    else if (evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // R6: the pointer steps by one on each replacement and otherwise holds.
  a_r6_rr_step: assert property (@(posedge clk) disable iff (rst)
    evict && (rr_q != LAST) |=> rr_q == $past(rr_q) + 1'b1);
  a_r6_rr_wrap: assert property (@(posedge clk) disable iff (rst)
    evict && (rr_q == LAST) |=> rr_q == '0);
  a_r5_rr_hold: assert property (@(posedge clk) disable iff (rst)
    !evict |=> $stable(rr_q));
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 16,
  parameter int VA_W    = 64,
  parameter int PA_W    = 48,
  parameter int PERM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_oaddr,
  output logic [PA_W-1:0]   rsp_mask,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VA_W-1:0]   fill_addr,
  input  logic [PA_W-1:0]   fill_oaddr,
  input  logic [PA_W-1:0]   fill_mask,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_valid,
  input  logic [1:0]        inv_cmd,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VA_W-1:0]   inv_addr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Entry state
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][VA_W-1:0]   addr_q;
  logic [ENTRIES-1:0][PA_W-1:0]   oaddr_q;
  logic [ENTRIES-1:0][PA_W-1:0]   mask_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  inv_cmd_e           cmd;
  logic [ENTRIES-1:0] inv_match, kill, live, lk_hit, fill_hit;
  logic [IDX_W-1:0]   victim;
  logic               fill_fire, lk_fire;

  assign cmd        = inv_cmd_e'(inv_cmd);
  assign lk_ready   = 1'b1;
  assign fill_ready = !inv_valid;
  assign fill_fire  = fill_valid && fill_ready;
  assign lk_fire    = lk_valid && lk_ready;

  // Invalidation scope: identifier-only or exact pair comparison
  iotlb_tag_match #(.N(ENTRIES), .ASID_W(ASID_W), .VA_W(VA_W)) u_inv_match (
    .valid(valid_q), .asid_tags(asid_q), .addr_tags(addr_q),
    .q_asid(inv_asid), .q_addr(inv_addr), .asid_only(cmd == INV_ASID),
    .hit(inv_match));

  always_comb begin
    kill = '0;
    if (inv_valid) begin
      case (cmd)
        INV_ALL:   kill = valid_q;
        INV_ASID:  kill = inv_match;
        INV_EXACT: kill = inv_match;
        default:   kill = '0;
      endcase
    end
  end

  // Lookup sees the cache with this cycle's invalidation already applied.
  assign live = valid_q & ~kill;

  iotlb_tag_match #(.N(ENTRIES), .ASID_W(ASID_W), .VA_W(VA_W)) u_lk_match (
    .valid(live), .asid_tags(asid_q), .addr_tags(addr_q),
    .q_asid(lk_asid), .q_addr(lk_addr), .asid_only(1'b0),
    .hit(lk_hit));

  iotlb_tag_match #(.N(ENTRIES), .ASID_W(ASID_W), .VA_W(VA_W)) u_fill_match (
    .valid(valid_q), .asid_tags(asid_q), .addr_tags(addr_q),
    .q_asid(fill_asid), .q_addr(fill_addr), .asid_only(1'b0),
    .hit(fill_hit));

  iotlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .valid(valid_q), .key_hit(fill_hit),
    .fill_fire(fill_fire), .victim(victim));

  // Payload select: at most one hit, so an OR of gated entries is exact.
  logic [PA_W-1:0]   sel_oaddr, sel_mask;
  logic [PERM_W-1:0] sel_perm;
  always_comb begin
    sel_oaddr = '0;
    sel_mask  = '0;
    sel_perm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit[i]) begin
        sel_oaddr = sel_oaddr | oaddr_q[i];
        sel_mask  = sel_mask  | mask_q[i];
        sel_perm  = sel_perm  | perm_q[i];
      end
    end
  end

  // Valid bits
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (kill[i])
          valid_q[i] <= 1'b0;
        if (fill_fire && (victim == IDX_W'(i)))
          valid_q[i] <= 1'b1;
      end
    end
  end

  // Tags and payload
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      asid_q[victim]  <= fill_asid;
      addr_q[victim]  <= fill_addr;
      oaddr_q[victim] <= fill_oaddr;
      mask_q[victim]  <= fill_mask;
      perm_q[victim]  <= fill_perm;
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_oaddr <= '0;
      rsp_mask  <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_fire;
      rsp_hit   <= lk_fire && (|lk_hit);
      rsp_oaddr <= lk_fire ? sel_oaddr : '0;
      rsp_mask  <= lk_fire ? sel_mask  : '0;
      rsp_perm  <= lk_fire ? sel_perm  : '0;
    end
  end

  // R2: one response per accepted lookup, one cycle later.
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_fire |=> rsp_valid);
  a_r2_rsp_only: assert property (@(posedge clk) disable iff (rst)
    !lk_fire |=> !rsp_valid);
  a_r2_hit_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  // R4: a key never lives in two entries.
  a_r4_single_copy: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit) && $onehot0(fill_hit));
  // R7: global invalidation empties the cache.
  a_r7_all_clear: assert property (@(posedge clk) disable iff (rst)
    inv_valid && (cmd == INV_ALL) |=> valid_q == '0);
  // R11: a lookup alongside a global invalidation misses.
  a_r11_inv_first: assert property (@(posedge clk) disable iff (rst)
    lk_fire && inv_valid && (cmd == INV_ALL) |=> !rsp_hit);
  // R3: fills are held off while an invalidation is presented.
  a_r3_fill_blocked: assert property (@(posedge clk) disable iff (rst)
    inv_valid && fill_valid |=> $stable(valid_q) || $past(cmd) != INV_NOP);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R8: identifier-wide invalidation removes each matching entry.
    a_r8_asid_clear: assert property (@(posedge clk) disable iff (rst)
      inv_valid && (cmd == INV_ASID) && (asid_q[g] == inv_asid) |=> !valid_q[g]);
    // R8: entries of other identifiers keep their valid bit.
    a_r8_asid_keep: assert property (@(posedge clk) disable iff (rst)
      inv_valid && (cmd == INV_ASID) && (asid_q[g] != inv_asid) |=>
      valid_q[g] == $past(valid_q[g]));
    // R9: exact-pair invalidation removes the matching entry.
    a_r9_exact_clear: assert property (@(posedge clk) disable iff (rst)
      inv_valid && (cmd == INV_EXACT) && (asid_q[g] == inv_asid) &&
      (addr_q[g] == inv_addr) |=> !valid_q[g]);
    // R10: the empty command leaves every entry as it was.
    a_r10_nop_keep: assert property (@(posedge clk) disable iff (rst)
      inv_valid && (cmd == INV_NOP) |=> valid_q[g] == $past(valid_q[g]));
  end
endmodule

// File: tb/tb_iotlb_cache.sv
module tb_iotlb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_ready, rsp_valid, rsp_hit;
  logic [15:0] lk_asid, fill_asid, inv_asid;
  logic [63:0] lk_addr, fill_addr, inv_addr;
  logic [47:0] rsp_oaddr, rsp_mask, fill_oaddr, fill_mask;
  logic [1:0]  rsp_perm, fill_perm, inv_cmd;
  logic        fill_valid, fill_ready, inv_valid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iotlb_cache dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_asid(lk_asid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_oaddr(rsp_oaddr),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_asid(fill_asid),
    .fill_addr(fill_addr), .fill_oaddr(fill_oaddr), .fill_mask(fill_mask),
    .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_cmd(inv_cmd), .inv_asid(inv_asid), .inv_addr(inv_addr));

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; inv_valid = 0;
  endtask

  task automatic do_fill(input logic [15:0] a, input logic [63:0] va,
                         input logic [47:0] pa, input logic [1:0] p);
    @(negedge clk);
    fill_valid = 1; fill_asid = a; fill_addr = va;
    fill_oaddr = pa; fill_mask = 48'hFFF; fill_perm = p;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_inv(input logic [1:0] c, input logic [15:0] a, input logic [63:0] va);
    @(negedge clk);
    inv_valid = 1; inv_cmd = c; inv_asid = a; inv_addr = va;
    @(negedge clk);
    inv_valid = 0;
  endtask

  // Issue a lookup and compare the response due one cycle later.
  task automatic do_look(input string req, input logic [15:0] a, input logic [63:0] va,
                         input logic hit, input logic [47:0] pa, input logic [1:0] p);
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_addr = va;
    @(negedge clk);
    lk_valid = 0;
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({req, " hit"}, 64'(rsp_hit), 64'(hit));
    check({req, " oaddr"}, 64'(rsp_oaddr), hit ? 64'(pa) : 64'd0);
    check({req, " mask"}, 64'(rsp_mask), hit ? 64'hFFF : 64'd0);
    check({req, " perm"}, 64'(rsp_perm), hit ? 64'(p) : 64'd0);
  endtask

  // Vector table: op 0 fill, 1 lookup, 2 invalidate
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] asid;
    logic [63:0] addr;
    logic [47:0] pa;
    logic [1:0]  perm;
    logic [1:0]  cmd;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 16'h1, 64'h1000, 48'hA1000, 2'd3, 2'd0, 1'b0, 4'd3},
    '{2'd0, 16'h2, 64'h1000, 48'hB1000, 2'd1, 2'd0, 1'b0, 4'd3},
    '{2'd0, 16'h1, 64'h2000, 48'hA2000, 2'd2, 2'd0, 1'b0, 4'd3},
    '{2'd1, 16'h1, 64'h1000, 48'hA1000, 2'd3, 2'd0, 1'b1, 4'd1},  // R1 both fields match
    '{2'd1, 16'h2, 64'h1000, 48'hB1000, 2'd1, 2'd0, 1'b1, 4'd1},  // R1 same address, other id
    '{2'd1, 16'h3, 64'h1000, 48'h0,     2'd0, 2'd0, 1'b0, 4'd1},  // R1 unknown id
    '{2'd1, 16'h1, 64'h1001, 48'h0,     2'd0, 2'd0, 1'b0, 4'd1},  // R1 address off by one
    '{2'd0, 16'h1, 64'h1000, 48'hA9000, 2'd1, 2'd0, 1'b0, 4'd4},  // R4 overwrite
    '{2'd1, 16'h1, 64'h1000, 48'hA9000, 2'd1, 2'd0, 1'b1, 4'd4},  // R4 new payload
    '{2'd2, 16'h2, 64'h1000, 48'h0,     2'd0, 2'd3, 1'b0, 4'd10}, // R10 empty command
    '{2'd1, 16'h2, 64'h1000, 48'hB1000, 2'd1, 2'd0, 1'b1, 4'd10}, // R10 entry kept
    '{2'd2, 16'h1, 64'h2000, 48'h0,     2'd0, 2'd2, 1'b0, 4'd9},  // R9 exact pair
    '{2'd1, 16'h1, 64'h2000, 48'h0,     2'd0, 2'd0, 1'b0, 4'd9},  // R9 removed
    '{2'd1, 16'h1, 64'h1000, 48'hA9000, 2'd1, 2'd0, 1'b1, 4'd9},  // R9 sibling kept
    '{2'd2, 16'h1, 64'h0,    48'h0,     2'd0, 2'd1, 1'b0, 4'd8},  // R8 by id
    '{2'd1, 16'h1, 64'h1000, 48'h0,     2'd0, 2'd0, 1'b0, 4'd8},  // R8 removed
    '{2'd1, 16'h2, 64'h1000, 48'hB1000, 2'd1, 2'd0, 1'b1, 4'd8},  // R8 other id kept
    '{2'd2, 16'h0, 64'h0,    48'h0,     2'd0, 2'd0, 1'b0, 4'd7},  // R7 all
    '{2'd1, 16'h2, 64'h1000, 48'h0,     2'd0, 2'd0, 1'b0, 4'd7}   // R7 gone
  };

  initial begin
    idle();
    lk_asid = 0; lk_addr = 0; fill_asid = 0; fill_addr = 0; fill_oaddr = 0;
    fill_mask = 0; fill_perm = 0; inv_cmd = 0; inv_asid = 0; inv_addr = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst = 0;
    // R2 / R3: ready levels
    @(negedge clk);
    check("R2 lk_ready", 64'(lk_ready), 64'd1);
    check("R3 fill_ready idle", 64'(fill_ready), 64'd1);
    do_look("R12 empty after reset", 16'h1, 64'h1000, 0, 0, 0);
    @(negedge clk);
    check("R2 rsp_valid single pulse", 64'(rsp_valid), 64'd0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[k].req, k);
      case (TBL[k].op)
        2'd0: do_fill(TBL[k].asid, TBL[k].addr, TBL[k].pa, TBL[k].perm);
        2'd1: do_look(tag, TBL[k].asid, TBL[k].addr, TBL[k].hit, TBL[k].pa, TBL[k].perm);
        default: do_inv(TBL[k].cmd, TBL[k].asid, TBL[k].addr);
      endcase
    end

    // R3: fill and lookup of the same key on one edge
    @(negedge clk);
    fill_valid = 1; fill_asid = 16'h9; fill_addr = 64'h9000;
    fill_oaddr = 48'h99000; fill_mask = 48'hFFF; fill_perm = 2'd2;
    lk_valid = 1; lk_asid = 16'h9; lk_addr = 64'h9000;
    @(negedge clk);
    idle();
    check("R3 same-cycle fill unseen", 64'(rsp_hit), 64'd0);
    do_look("R3 fill seen next", 16'h9, 64'h9000, 1, 48'h99000, 2'd2);

    // R3: fill held while an invalidation is presented
    @(negedge clk);
    inv_valid = 1; inv_cmd = 2'd3; fill_valid = 1; fill_asid = 16'hA;
    fill_addr = 64'hA000; fill_oaddr = 48'hAA000;
    #1 check("R3 fill_ready low during inv", 64'(fill_ready), 64'd0);
    @(negedge clk);
    idle();
    do_look("R3 blocked fill not written", 16'hA, 64'hA000, 0, 0, 0);

    // R5 / R6: fill all entries, then replace
    do_inv(2'd0, 0, 0);
    for (int i = 0; i < N; i++) do_fill(16'h5, 64'(i) << 12, 48'(i + 16'h100), 2'd1);
    do_fill(16'h5, 64'h3000, 48'h333, 2'd3);                 // R4 overwrite while full
    do_fill(16'h5, 64'(16) << 12, 48'h110, 2'd1);           // evicts entry 0
    do_look("R6 first victim entry 0", 16'h5, 64'h0, 0, 0, 0);
    do_look("R6 entry 1 kept", 16'h5, 64'h1000, 1, 48'h101, 2'd1);
    do_look("R4 overwrite no duplicate", 16'h5, 64'h3000, 1, 48'h333, 2'd3);
    do_look("R6 new key present", 16'h5, 64'h10000, 1, 48'h110, 2'd1);
    do_fill(16'h5, 64'(17) << 12, 48'h111, 2'd1);           // evicts entry 1
    do_look("R6 pointer advanced", 16'h5, 64'h1000, 0, 0, 0);
    do_look("R6 entry 2 kept", 16'h5, 64'h2000, 1, 48'h102, 2'd1);
    do_inv(2'd2, 16'h5, 64'h7000);
    do_fill(16'h5, 64'(18) << 12, 48'h112, 2'd1);           // R5 takes free entry 7
    do_fill(16'h5, 64'(19) << 12, 48'h113, 2'd1);           // evicts entry 2
    do_look("R5 free slot used", 16'h5, 64'h12000, 1, 48'h112, 2'd1);
    do_look("R5 pointer held", 16'h5, 64'h2000, 0, 0, 0);
    do_look("R5 entry 3 kept", 16'h5, 64'h3000, 1, 48'h333, 2'd3);

    // R11: invalidation with lookup on one edge
    @(negedge clk);
    inv_valid = 1; inv_cmd = 2'd0;
    lk_valid = 1; lk_asid = 16'h5; lk_addr = 64'h10000;
    @(negedge clk);
    idle();
    check("R11 lookup misses cleared entry", 64'(rsp_hit), 64'd0);
    check("R11 rsp_valid", 64'(rsp_valid), 64'd1);

    // R12: reset empties a populated cache
    do_fill(16'h7, 64'h7000, 48'h777, 2'd1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    do_look("R12 reset clears entries", 16'h7, 64'h7000, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule